// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two bidirectional data buses, called A and B. Each direction can do one of two things. It can forward the opposite bus in real time, or it can drive a word that was captured earlier into that direction's own storage register.

The word is split into independent halves. Each half has a full set of controls:

- a capture clock for each direction;
- a source select for each direction, where low picks live data and high picks stored data;
- an output enable for each direction.

So the block can serve as several narrow transceivers or as one wide one. Each bus appears at the ports as three vectors: an input, an output and an output enable. A pad or tri-state wrapper outside the block resolves them.

Typical uses:

- forward live traffic;
- snapshot one bus while neither side is driven;
- replay a stored snapshot onto the other bus;
- enable both directions in live mode so each bus reinforces the other, which lets external bus keepers hold the last value.

Top module: `bxcvr_top`

## Requirements
- R1: A rising edge on `ab_clk[h]` loads half h of `a_in` into the A-to-B register. While `ab_sel[h]` is 1, half h of `b_out` shows that register.
- R2: A rising edge on `ba_clk[h]` loads half h of `b_in` into the B-to-A register. While `ba_sel[h]` is 1, half h of `a_out` shows that register.
- R3: Capture happens on every rising capture-clock edge, whatever the values of the select and output-enable inputs. A word captured while live data or disabled drivers were in effect appears once the select is set to 1.
- R4: While `ab_sel[h]` is 0, half h of `b_out` equals half h of `a_in` with no clock involved. The output is always exactly the live word or exactly the stored word.
- R5: While `ba_sel[h]` is 0, half h of `a_out` equals half h of `b_in` with no clock involved.
- R6: `ab_oe[h]` is active high. Every bit of half h of `b_oe` equals `ab_oe[h]`.
- R7: `ba_oe_n[h]` is active low. Every bit of half h of `a_oe` equals the inverse of `ba_oe_n[h]`.
- R8: Half h (bits h*HALF_W upward) depends only on the controls indexed h. Clocking, selecting or enabling one half leaves the other half's outputs unchanged.
- R9: While `rst_n` is 0, both registers of every half read zero, without waiting for any clock edge.
- R10: With both selects at 0 and both directions enabled, `b_out` mirrors `a_in`, `a_out` mirrors `b_in`, and both `a_oe` and `b_oe` are all ones. This forms the mutual-drive loop that holds the buses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low clear of all storage registers |
| ab_clk | input | NUM_HALVES | Per-half capture clock for the A-to-B register (rising edge) |
| ba_clk | input | NUM_HALVES | Per-half capture clock for the B-to-A register (rising edge) |
| ab_sel | input | NUM_HALVES | Per-half source for B drive: 0 live A, 1 stored |
| ba_sel | input | NUM_HALVES | Per-half source for A drive: 0 live B, 1 stored |
| ab_oe | input | NUM_HALVES | Per-half active-high enable of the B-side drivers |
| ba_oe_n | input | NUM_HALVES | Per-half active-low enable of the A-side drivers |
| a_in | input | NUM_HALVES*HALF_W | Value seen on bus A |
| b_in | input | NUM_HALVES*HALF_W | Value seen on bus B |
| a_out | output | NUM_HALVES*HALF_W | Data offered to bus A |
| a_oe | output | NUM_HALVES*HALF_W | Per-bit drive enable for bus A |
| b_out | output | NUM_HALVES*HALF_W | Data offered to bus B |
| b_oe | output | NUM_HALVES*HALF_W | Per-bit drive enable for bus B |

## Verification
The bench builds the block with its defaults: two halves of eight bits, which gives a sixteen-bit word. With two halves, the bench can clock, select and enable one half against the other and check that the untouched byte keeps its value. It also drives patterns in which the high and low bytes differ in every bit, so a slice crossing between halves would show up at once. Because every half has its own capture clocks, the bench can capture in one direction only and confirm that the other direction's stored word does not move.

// File: rtl/bxcvr_pkg.sv
package bxcvr_pkg;

  // Source chosen for the word a direction offers to its destination bus.
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_e;

  // Turn an enable pin into an active-high drive level.
  function automatic logic drive_level(input logic pin, input logic active_low);
    return active_low ? ~pin : pin;
  endfunction

endpackage

// File: rtl/bxcvr_store.sv
module bxcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // Edge-triggered snapshot; never gated by select or enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/bxcvr_lane.sv
module bxcvr_lane
  import bxcvr_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          rst_n,
  input  logic          ab_clk,
  input  logic          ba_clk,
  input  logic          ab_sel,
  input  logic          ba_sel,
  input  logic          ab_oe,
  input  logic          ba_oe_n,
  input  logic [LW-1:0] a_in,
  input  logic [LW-1:0] b_in,
  output logic [LW-1:0] a_out,
  output logic [LW-1:0] a_oe,
  output logic [LW-1:0] b_out,
  output logic [LW-1:0] b_oe
);

  // AND-OR steering with one shared select: every bit is either the live
  // bit or the held bit, never a mixture of partially decoded terms.
  function automatic logic [LW-1:0] steer(input logic [LW-1:0] live,
                                          input logic [LW-1:0] held,
                                          input src_e          src);
    logic [LW-1:0] m;
    m = {LW{src == SRC_HELD}};
    return (live & ~m) | (held & m);
  endfunction

  // Named internal events
  logic [LW-1:0] ab_held;      // word stored for the A-to-B direction
  logic [LW-1:0] ba_held;      // word stored for the B-to-A direction
  src_e          ab_src;
  src_e          ba_src;
  logic          b_drive_en;
  logic          a_drive_en;

  bxcvr_store #(.WIDTH(LW)) u_ab_reg (
    .clk   (ab_clk),
    .rst_n (rst_n),
    .d     (a_in),
    .q     (ab_held)
  );

  bxcvr_store #(.WIDTH(LW)) u_ba_reg (
    .clk   (ba_clk),
    .rst_n (rst_n),
    .d     (b_in),
    .q     (ba_held)
  );

  assign ab_src     = src_e'(ab_sel);
  assign ba_src     = src_e'(ba_sel);
  assign b_drive_en = drive_level(ab_oe, 1'b0);
  assign a_drive_en = drive_level(ba_oe_n, 1'b1);

  assign b_out = steer(a_in, ab_held, ab_src);
  assign a_out = steer(b_in, ba_held, ba_src);
  assign b_oe  = {LW{b_drive_en}};
  assign a_oe  = {LW{a_drive_en}};

endmodule

// File: rtl/bxcvr_top.sv
module bxcvr_top #(
  parameter int NUM_HALVES = 2,
  parameter int HALF_W     = 8
) (
  input  logic                         rst_n,
  input  logic [NUM_HALVES-1:0]        ab_clk,
  input  logic [NUM_HALVES-1:0]        ba_clk,
  input  logic [NUM_HALVES-1:0]        ab_sel,
  input  logic [NUM_HALVES-1:0]        ba_sel,
  input  logic [NUM_HALVES-1:0]        ab_oe,
  input  logic [NUM_HALVES-1:0]        ba_oe_n,
  input  logic [NUM_HALVES*HALF_W-1:0] a_in,
  input  logic [NUM_HALVES*HALF_W-1:0] b_in,
  output logic [NUM_HALVES*HALF_W-1:0] a_out,
  output logic [NUM_HALVES*HALF_W-1:0] a_oe,
  output logic [NUM_HALVES*HALF_W-1:0] b_out,
  output logic [NUM_HALVES*HALF_W-1:0] b_oe
);

  localparam int WORD_W = NUM_HALVES * HALF_W;

  // One fully independent transceiver per half.
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    bxcvr_lane #(.LW(HALF_W)) u_lane (
      .rst_n   (rst_n),
      .ab_clk  (ab_clk[h]),
      .ba_clk  (ba_clk[h]),
      .ab_sel  (ab_sel[h]),
      .ba_sel  (ba_sel[h]),
      .ab_oe   (ab_oe[h]),
      .ba_oe_n (ba_oe_n[h]),
      .a_in    (a_in[h*HALF_W +: HALF_W]),
      .b_in    (b_in[h*HALF_W +: HALF_W]),
      .a_out   (a_out[h*HALF_W +: HALF_W]),
      .a_oe    (a_oe[h*HALF_W +: HALF_W]),
      .b_out   (b_out[h*HALF_W +: HALF_W]),
      .b_oe    (b_oe[h*HALF_W +: HALF_W])
    );
  end

  if (WORD_W < 1) begin : g_bad_width
    initial $error("bxcvr_top: word width must be positive");
  end

endmodule

// File: rtl/bxcvr_chk.sv
module bxcvr_chk #(
  parameter int NUM_HALVES = 2,
  parameter int HALF_W     = 8
) (
  input logic                         rst_n,
  input logic [NUM_HALVES-1:0]        ab_clk,
  input logic [NUM_HALVES-1:0]        ba_clk,
  input logic [NUM_HALVES-1:0]        ab_sel,
  input logic [NUM_HALVES-1:0]        ba_sel,
  input logic [NUM_HALVES-1:0]        ab_oe,
  input logic [NUM_HALVES-1:0]        ba_oe_n,
  input logic [NUM_HALVES*HALF_W-1:0] a_in,
  input logic [NUM_HALVES*HALF_W-1:0] b_in,
  input logic [NUM_HALVES*HALF_W-1:0] a_out,
  input logic [NUM_HALVES*HALF_W-1:0] a_oe,
  input logic [NUM_HALVES*HALF_W-1:0] b_out,
  input logic [NUM_HALVES*HALF_W-1:0] b_oe
);

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_chk
    // Set after the first capture edge since reset, so $past has a real value.
    logic ab_primed;
    logic ba_primed;

    always_ff @(posedge ab_clk[h] or negedge rst_n) begin
      if (!rst_n) ab_primed <= 1'b0;
      else        ab_primed <= 1'b1;
    end

    always_ff @(posedge ba_clk[h] or negedge rst_n) begin
      if (!rst_n) ba_primed <= 1'b0;
      else        ba_primed <= 1'b1;
    end

    AST_AB_HELD: assert property (@(posedge ab_clk[h]) disable iff (!rst_n || !ab_primed)
      ab_sel[h] |-> b_out[h*HALF_W +: HALF_W] == $past(a_in[h*HALF_W +: HALF_W]));  // R1
    AST_BA_HELD: assert property (@(posedge ba_clk[h]) disable iff (!rst_n || !ba_primed)
      ba_sel[h] |-> a_out[h*HALF_W +: HALF_W] == $past(b_in[h*HALF_W +: HALF_W]));  // R2
    AST_AB_LIVE: assert property (@(posedge ab_clk[h]) disable iff (!rst_n)
      !ab_sel[h] |-> b_out[h*HALF_W +: HALF_W] == a_in[h*HALF_W +: HALF_W]);  // R4
    AST_BA_LIVE: assert property (@(posedge ba_clk[h]) disable iff (!rst_n)
      !ba_sel[h] |-> a_out[h*HALF_W +: HALF_W] == b_in[h*HALF_W +: HALF_W]);  // R5
    AST_B_ENABLE: assert property (@(posedge ab_clk[h]) disable iff (!rst_n)
      b_oe[h*HALF_W +: HALF_W] == {HALF_W{ab_oe[h]}});  // R6
    AST_A_ENABLE: assert property (@(posedge ba_clk[h]) disable iff (!rst_n)
      a_oe[h*HALF_W +: HALF_W] == {HALF_W{~ba_oe_n[h]}});  // R7
  end

endmodule

bind bxcvr_top bxcvr_chk #(
  .NUM_HALVES (NUM_HALVES),
  .HALF_W     (HALF_W)
) u_chk (
  .rst_n   (rst_n),
  .ab_clk  (ab_clk),
  .ba_clk  (ba_clk),
  .ab_sel  (ab_sel),
  .ba_sel  (ba_sel),
  .ab_oe   (ab_oe),
  .ba_oe_n (ba_oe_n),
  .a_in    (a_in),
  .b_in    (b_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_out   (b_out),
  .b_oe    (b_oe)
);

// File: tb/bxcvr_top_bench.sv
`timescale 1ns/1ps
module bxcvr_top_bench;

  localparam int NH = 2;
  localparam int HW = 8;
  localparam int W  = NH * HW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NH-1:0] ab_clk, ba_clk, ab_sel, ba_sel, ab_oe, ba_oe_n;
  logic [W-1:0]  a_in, b_in;
  logic [W-1:0]  a_out, a_oe, b_out, b_oe;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  bxcvr_top #(.NUM_HALVES(NH), .HALF_W(HW)) u_bxcvr_top (
    .rst_n (rst_n), .ab_clk (ab_clk), .ba_clk (ba_clk),
    .ab_sel (ab_sel), .ba_sel (ba_sel), .ab_oe (ab_oe), .ba_oe_n (ba_oe_n),
    .a_in (a_in), .b_in (b_in),
    .a_out (a_out), .a_oe (a_oe), .b_out (b_out), .b_oe (b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [NH-1:0] abm, input logic [NH-1:0] bam);
    @(negedge clk);
    ab_clk = abm;
    ba_clk = bam;
    @(negedge clk);
    ab_clk = '0;
    ba_clk = '0;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ab_clk = '0; ba_clk = '0;
    ab_sel = '1; ba_sel = '1; ab_oe = '0; ba_oe_n = '1;
    a_in = 16'hFFFF; b_in = 16'hFFFF;
    #3;
    chk("R9 b_out in reset", b_out, 16'h0000);
    chk("R9 a_out in reset", a_out, 16'h0000);
    chk("R6 b_oe off", b_oe, 16'h0000);
    chk("R7 a_oe off", a_oe, 16'h0000);
    @(negedge clk); rst_n = 1'b1; #1;
  endtask

  task automatic t_live_ab();
    ab_sel = '0; ab_oe = '1;
    a_in = 16'h5AC3; #1;
    chk("R4 live A to B", b_out, 16'h5AC3);
    chk("R6 b_oe on", b_oe, 16'hFFFF);
    a_in = 16'h0F1E; #1;
    chk("R4 live A to B follows", b_out, 16'h0F1E);
  endtask

  task automatic t_live_ba();
    ba_sel = '0; ba_oe_n = '0;
    b_in = 16'h9C27; #1;
    chk("R5 live B to A", a_out, 16'h9C27);
    chk("R7 a_oe on", a_oe, 16'hFFFF);
  endtask

  task automatic t_store_quiet();
    ab_oe = '0; ba_oe_n = '1; ab_sel = '0; ba_sel = '0;
    a_in = 16'h1234; b_in = 16'hABCD;
    pulse('1, '1);
    chk("R6 no B drive while storing", b_oe, 16'h0000);
    chk("R7 no A drive while storing", a_oe, 16'h0000);
    a_in = 16'hFFFF; b_in = 16'h0000;
    ab_sel = '1; ba_sel = '1; #1;
    chk("R1 stored A word", b_out, 16'h1234);
    chk("R2 stored B word", a_out, 16'hABCD);
  endtask

  task automatic t_drive_stored();
    ab_oe = '1; ba_oe_n = '0;
    a_in = 16'hC0DE; b_in = 16'hBEEF; #1;
    chk("R1 held before edge", b_out, 16'h1234);
    pulse('1, '1);
    chk("R1 replay after edge", b_out, 16'hC0DE);
    chk("R2 replay after edge", a_out, 16'hBEEF);
  endtask

  task automatic t_capture_indep();
    ab_sel = '0; ab_oe = '1;
    a_in = 16'h7E81;
    pulse('1, '0);
    chk("R4 live during capture", b_out, 16'h7E81);
    a_in = 16'h0000; ab_sel = '1; #1;
    chk("R3 captured under live select", b_out, 16'h7E81);
    chk("R2 B-to-A untouched", a_out, 16'hBEEF);
    ab_oe = '0; a_in = 16'h4242;
    pulse('1, '0);
    chk("R3 captured with drivers off", b_out, 16'h4242);
  endtask

  task automatic t_halves();
    ab_sel = '1; a_in = 16'hAA55;
    pulse(2'b01, 2'b00);
    chk("R8 only low half captured", b_out, 16'h4255);
    ab_sel = 2'b10; a_in = 16'h1177; #1;
    chk("R8 mixed select per half", b_out, 16'h4277);
    ab_oe = 2'b01; ba_oe_n = 2'b01; #1;
    chk("R8 B enable per half", b_oe, 16'h00FF);
    chk("R8 A enable per half", a_oe, 16'hFF00);
  endtask

  task automatic t_loop();
    ab_sel = '0; ba_sel = '0; ab_oe = '1; ba_oe_n = '0;
    a_in = 16'h3C3C; b_in = 16'hC3C3; #1;
    chk("R10 B mirrors A", b_out, 16'h3C3C);
    chk("R10 A mirrors B", a_out, 16'hC3C3);
    chk("R10 both B enabled", b_oe, 16'hFFFF);
    chk("R10 both A enabled", a_oe, 16'hFFFF);
  endtask

  task automatic t_async_reset();
    a_in = 16'h9999; b_in = 16'h6666;
    pulse('1, '1);
    ab_sel = '1; ba_sel = '1; #1;
    chk("R1 before clear", b_out, 16'h9999);
    @(negedge clk); #1;
    rst_n = 1'b0; #1;
    chk("R9 async clear B side", b_out, 16'h0000);
    chk("R9 async clear A side", a_out, 16'h0000);
    rst_n = 1'b1; #1;
  endtask

  initial begin
    t_reset();
    t_live_ab();
    t_live_ba();
    t_store_quiet();
    t_drive_stored();
    t_capture_indep();
    t_halves();
    t_loop();
    t_async_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule